// File: doc/BRIEF.md
# Nibble-Multiplexed Chroma Demultiplexer

This block rebuilds 8-bit U and V colour-difference samples from a 4-bit chroma bus. A colour decoder sends these samples four bits at a time on the bus. Each U/V pair takes four clock periods to arrive. The nibbles come in a fixed interleaved order: U high, V low, V high, U low. The block must therefore know which clock of the group it is in before it can place each nibble.

The block does not use a separate framing line to find that position. During vertical blanking the decoder sends a sync pulse on bus line 0, and the block uses the rising edge of this pulse to align its phase counter. After alignment the counter runs freely. A complete pair is shown on the U and V outputs together with a valid strobe that lasts one cycle. A format input selects 4:2:2 framing, where every group gives a pair, or 4:1:1 framing, where only every second group gives a pair.

Top module: `chroma_nibble_demux`

## Requirements
- R1: While reset is asserted (synchronous, active low), `valid_o` is 0 and `u_o` and `v_o` are 0.
- R2: After reset, `valid_o` stays 0 until the first alignment event. This holds whatever data is on the bus.
- R3: An alignment event is a clock where `vblank_i` is 1, `nib_i[0]` is 1, and `nib_i[0]` was 0 on the previous clock. That clock carries no data. The slot counter then restarts, so the next clock holds the U high nibble. A partly received group is dropped.
- R4: Within a group the slots are 0 = U[7:4], 1 = V[3:0], 2 = V[7:4] and 3 = U[3:0]. The outputs are U = {slot0, slot3} and V = {slot2, slot1}.
- R5: `valid_o` rises in the clock after the U low nibble is captured and stays high for exactly one cycle. `u_o` and `v_o` hold the pair in that cycle.
- R6: In 4:2:2 mode (`fmt_411_i` = 0), every four-clock group gives one pair, and the pairs are four clocks apart.
- R7: In 4:1:1 mode (`fmt_411_i` = 1), the first group after alignment gives a pair. After that only every second group gives one.
- R8: A change on `fmt_411_i` takes effect only at the next alignment event.
- R9: Outside vertical blanking, a rising edge on bus line 0 is ignored. The slot counter keeps counting modulo 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nib_i | input | 4 | Multiplexed chroma nibble bus; bit 0 also carries the sync pulse |
| vblank_i | input | 1 | High during vertical blanking |
| fmt_411_i | input | 1 | 0 = 4:2:2 framing, 1 = 4:1:1 framing |
| u_o | output | 8 | Rebuilt U sample |
| v_o | output | 8 | Rebuilt V sample |
| valid_o | output | 1 | One-cycle strobe marking a new U/V pair |

## Verification
The bench checks that a sync pulse in the middle of a group realigns the phase and drops the partial group. A design that kept the stale nibbles, or that captured data on the sync clock, would output a shifted U or V. The data itself contains rising edges on line 0 outside blanking. A design that realigned on those edges would garble the following pairs. In 4:1:1 mode the bench checks that the strobe appears on alternate groups, starting with the first. It also checks that a format change made without a sync pulse leaves the cadence unchanged until the next alignment. Strobes sent before the first alignment count as failures.

// File: rtl/chroma_demux_pkg.sv
`timescale 1ns/1ps
// Shared slot encoding for the nibble demultiplexer.
// Slot order is behavioural: it fixes where each nibble lands.
package chroma_demux_pkg;
    localparam int SLOT_CNT = 4;
    localparam int SLOT_W   = $clog2(SLOT_CNT);

    typedef enum logic [SLOT_W-1:0] {
        SLOT_U_HI = 2'd0,
        SLOT_V_LO = 2'd1,
        SLOT_V_HI = 2'd2,
        SLOT_U_LO = 2'd3
    } slot_e;
endpackage

// File: rtl/chroma_phase_track.sv
`timescale 1ns/1ps
// Phase tracker: detects the in-band sync edge on one bus line during
// blanking and keeps a modulo-4 slot counter.
// Assumes: the sync line is low for at least one clock before its pulse.
module chroma_phase_track
    import chroma_demux_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sync_i,
    input  logic  vblank_i,
    output slot_e slot_o,
    output logic  align_o,
    output logic  locked_o
);
    logic  sync_q;
    slot_e slot_q;
    logic  locked_q;

    assign align_o  = vblank_i & sync_i & ~sync_q;
    assign slot_o   = slot_q;
    assign locked_o = locked_q;

    // Keep the previous level of the sync line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_i;
    end

    // Restart the slot count on alignment; otherwise advance modulo 4.
    always_ff @(posedge clk) begin
        if (!rst_n)       slot_q <= SLOT_U_HI;
        else if (align_o) slot_q <= SLOT_U_HI;
        else              slot_q <= slot_e'(slot_q + 2'd1);
    end

    // Record that at least one alignment has happened.
    always_ff @(posedge clk) begin
        if (!rst_n)       locked_q <= 1'b0;
        else if (align_o) locked_q <= 1'b1;
    end

    AST_ALIGN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        align_o |=> slot_q == SLOT_U_HI); // R3
    AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !align_o |=> slot_q == slot_e'($past(slot_q) + 2'd1)); // R9
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> locked_q); // R2
endmodule

// File: rtl/chroma_pair_gate.sv
`timescale 1ns/1ps
// Pair gate: decides which completed groups produce an output pair,
// based on the format latched at the last alignment.
// Assumes: slot_i and align_i come from the phase tracker.
module chroma_pair_gate
    import chroma_demux_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fmt_411_i,
    input  slot_e slot_i,
    input  logic  align_i,
    input  logic  locked_i,
    output logic  emit_o
);
    logic fmt_q;
    logic skip_q;
    logic group_end;

    assign group_end = (slot_i == SLOT_U_LO) && !align_i;
    assign emit_o    = locked_i && group_end && (!fmt_q || !skip_q);

    // Latch the format select only at an alignment event.
    always_ff @(posedge clk) begin
        if (!rst_n)       fmt_q <= 1'b0;
        else if (align_i) fmt_q <= fmt_411_i;
    end

    // Alternate emitted and skipped groups in 4:1:1 mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                  skip_q <= 1'b0;
        else if (align_i)            skip_q <= 1'b0;
        else if (group_end && fmt_q) skip_q <= ~skip_q;
    end

    AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !align_i |=> $stable(fmt_q)); // R8
    AST_411_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_o && fmt_q) |=> skip_q); // R7
endmodule

// File: rtl/chroma_nibble_assemble.sv
`timescale 1ns/1ps
// Nibble assembler: stores nibbles by slot and registers a full U/V pair
// with a one-cycle strobe when the gate requests it.
// Assumes: emit_i is only asserted in the U low slot.
module chroma_nibble_assemble
    import chroma_demux_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int SAMP_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  nib_i,
    input  slot_e             slot_i,
    input  logic              align_i,
    input  logic              emit_i,
    output logic [SAMP_W-1:0] u_o,
    output logic [SAMP_W-1:0] v_o,
    output logic              valid_o
);
    logic [NIB_W-1:0] u_hi_q, v_lo_q, v_hi_q;

    // Store the first three nibbles of a group by slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_hi_q <= '0;
            v_lo_q <= '0;
            v_hi_q <= '0;
        end else if (!align_i) begin
            case (slot_i)
                SLOT_U_HI: u_hi_q <= nib_i;
                SLOT_V_LO: v_lo_q <= nib_i;
                SLOT_V_HI: v_hi_q <= nib_i;
                default:   ;
            endcase
        end
    end

    // Register the finished pair and pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_o     <= '0;
            v_o     <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= emit_i;
            if (emit_i) begin
                u_o <= {u_hi_q, nib_i};
                v_o <= {v_hi_q, v_lo_q};
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R5
    AST_VALID_AFTER_ULO: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(slot_i) == SLOT_U_LO); // R5
    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !emit_i |=> $stable(u_o) && $stable(v_o)); // R5
endmodule

// File: rtl/chroma_nibble_demux.sv
`timescale 1ns/1ps
// Top: nibble-multiplexed chroma demultiplexer. Recovers the nibble phase
// from a sync pulse on one bus line during blanking and rebuilds U and V.
// Assumes: one nibble per main clock, slot order U hi, V lo, V hi, U lo.
module chroma_nibble_demux
    import chroma_demux_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int SYNC_BIT = 0,
    localparam int SAMP_W  = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  nib_i,
    input  logic              vblank_i,
    input  logic              fmt_411_i,
    output logic [SAMP_W-1:0] u_o,
    output logic [SAMP_W-1:0] v_o,
    output logic              valid_o
);
    slot_e slot;
    logic  align;
    logic  locked;
    logic  emit;

    chroma_phase_track i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (nib_i[SYNC_BIT]),
        .vblank_i (vblank_i),
        .slot_o   (slot),
        .align_o  (align),
        .locked_o (locked)
    );

    chroma_pair_gate i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_411_i (fmt_411_i),
        .slot_i    (slot),
        .align_i   (align),
        .locked_i  (locked),
        .emit_o    (emit)
    );

    chroma_nibble_assemble #(.NIB_W(NIB_W)) i_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .nib_i   (nib_i),
        .slot_i  (slot),
        .align_i (align),
        .emit_i  (emit),
        .u_o     (u_o),
        .v_o     (v_o),
        .valid_o (valid_o)
    );

    AST_NO_VALID_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> locked); // R2
    AST_NO_CAPTURE_ON_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        align |=> !valid_o); // R3
endmodule

// File: tb/test_chroma_nibble_demux.sv
`timescale 1ns/1ps
// Bench for the chroma demultiplexer: a vector table walked in 4:2:2 mode,
// then directed tests for reset, lock, realignment and 4:1:1 cadence.
module test_chroma_nibble_demux;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] nib = 4'h0;
    logic       vblank = 1'b0;
    logic       fmt411 = 1'b0;
    logic [7:0] u_o, v_o;
    logic       valid_o;
    int         n_chk = 0;
    int         n_bad = 0;

    always #5 clk = ~clk;

    chroma_nibble_demux i_chroma_nibble_demux (
        .clk(clk), .rst_n(rst_n), .nib_i(nib), .vblank_i(vblank),
        .fmt_411_i(fmt411), .u_o(u_o), .v_o(v_o), .valid_o(valid_o)
    );

    // {U, V}; several contain rising edges on bus line 0 outside blanking.
    localparam logic [15:0] VEC [8] = '{
        16'h3A_C5, 16'h01_10, 16'hFF_00, 16'h00_FF,
        16'h5A_A5, 16'h91_19, 16'h7E_E7, 16'h21_12
    };

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; drives one group. Returns at the negedge where
    // the group's result is visible.
    task automatic send_group(input logic [7:0] u, input logic [7:0] v,
                              input bit exp_valid, input string req);
        nib = u[7:4];
        @(negedge clk);
        chk(valid_o == 1'b0, "R5 strobe low mid-group", {15'd0, valid_o}, 16'd0);
        nib = v[3:0];
        @(negedge clk);
        chk(valid_o == 1'b0, "R5 strobe low mid-group", {15'd0, valid_o}, 16'd0);
        nib = v[7:4];
        @(negedge clk);
        chk(valid_o == 1'b0, "R5 strobe low mid-group", {15'd0, valid_o}, 16'd0);
        nib = u[3:0];
        @(negedge clk);
        if (exp_valid)
            chk(valid_o && u_o == u && v_o == v, req,
                {u_o, v_o} ^ {15'd0, !valid_o}, {u, v});
        else
            chk(valid_o == 1'b0, req, {15'd0, valid_o}, 16'd0);
    endtask

    // Called at a negedge; emits one blanking sync pulse on line 0.
    task automatic send_sync();
        vblank = 1'b1;
        nib = 4'h0;
        @(negedge clk);
        nib = 4'h1;
        @(negedge clk);
        vblank = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(valid_o == 1'b0 && u_o == 8'h00 && v_o == 8'h00, "R1 reset state",
            {u_o, v_o} | {15'd0, valid_o}, 16'h0000);
        rst_n = 1'b1;

        // R2: no strobe before any alignment
        send_group(8'h3C, 8'h5A, 1'b0, "R2 no strobe before lock");
        send_group(8'hC3, 8'hA5, 1'b0, "R2 no strobe before lock");
        send_group(8'h11, 8'h22, 1'b0, "R2 no strobe before lock");

        // R3/R4/R6/R9: align, then walk the table back to back in 4:2:2
        send_sync();
        for (int i = 0; i < 8; i++)
            send_group(VEC[i][15:8], VEC[i][7:0], 1'b1, "R4 R6 R9 pair decode");

        // R3: a sync in the middle of a group drops the partial group
        nib = 4'h7; @(negedge clk);
        nib = 4'h9; @(negedge clk);
        send_sync();
        send_group(8'hB4, 8'h6D, 1'b1, "R3 realign mid-group");

        // R7: 4:1:1 cadence, the first group after alignment emits
        fmt411 = 1'b1;
        send_sync();
        send_group(8'h12, 8'h34, 1'b1, "R7 first 411 group emits");
        send_group(8'h56, 8'h78, 1'b0, "R7 second 411 group skipped");
        send_group(8'h9A, 8'hBC, 1'b1, "R7 third 411 group emits");
        send_group(8'hDE, 8'hF0, 1'b0, "R7 fourth 411 group skipped");

        // R8: a format change without alignment keeps the 4:1:1 cadence
        fmt411 = 1'b0;
        send_group(8'h4B, 8'hB4, 1'b1, "R8 format held until align");
        send_group(8'h2D, 8'hD2, 1'b0, "R8 format held until align");

        // R8: the next alignment applies 4:2:2
        send_sync();
        send_group(8'h81, 8'h18, 1'b1, "R8 new format after align");
        send_group(8'h7F, 8'hF7, 1'b1, "R8 new format after align");

        // R1: asserting reset again clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk(valid_o == 1'b0 && u_o == 8'h00 && v_o == 8'h00, "R1 reset clears",
            {u_o, v_o} | {15'd0, valid_o}, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule